// File: doc/BRIEF.md
# Differential Link Delay Monitor

This block keeps track of how far each link of a bonded group lags in transit, counted in whole cells. An upstream measurement stage hands it one delay figure at a time, tagged with the link it belongs to. The block stores the latest figure per link. From those figures it derives the largest and the smallest delay among the links enabled in the group, along with the link that produces each extreme. It also keeps a peak value that only grows until it is cleared on purpose. The link with the largest delay is the one that needs the fewest cells buffered to realign the cell stream, and the one with the smallest delay needs the most. The two extremes therefore bound the buffering the group needs.

Software reads any of these values through an indirect port. It first presents a select holding a 2-bit kind code and a link number. Exactly two clock cycles later, an 11-bit delay and a link number appear on the read outputs. A busy flag covers the cycles in between. The read outputs keep their value until the next select has finished.

Top module: `link_delay_monitor`

## Requirements
- R1: After reset, every stored per-link delay, the current maximum and minimum, the held peak and the read outputs are zero (link number 0), and busy is low.
- R2: When updValid is high at a clock edge, updDelay is stored as the delay of link updLink. A read of kind 3 returns that link's stored delay on rdDelay and echoes the selected link number on rdLink.
- R3: A read of kind 1 returns the largest stored delay among the links enabled in groupMask, and the lowest-numbered enabled link that holds it.
- R4: A read of kind 2 returns the smallest stored delay among the enabled links, and the lowest-numbered enabled link that holds it. With no link enabled, kinds 1 and 2 both return delay 0 and link 0.
- R5: A link whose groupMask bit is 0 has no influence on the maximum or the minimum, whatever delay it stores.
- R6: A read of kind 0 returns the held peak and its link. The peak takes the current maximum and its link only when the maximum is strictly greater than the peak, so the peak never decreases without a clear.
- R7: A pulse on heldClr sets the held peak to 0 and its link to 0. While groupMask is empty, the peak then stays at 0.
- R8: rdDelay and rdLink take their new values at the second rising edge after the edge that samples selWrite high. busy is high for exactly the two cycles in between.
- R9: While no read is in progress, rdDelay and rdLink keep their values, even while delays, the mask or the peak change.
- R10: A selWrite that arrives while busy is high restarts the two-cycle sequence, and the last select wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| updValid | input | 1 | Delay update strobe |
| updLink | input | 3 | Link number of the update |
| updDelay | input | 11 | New delay of that link, in cells |
| groupMask | input | 8 | One enable bit per link for the max/min search |
| heldClr | input | 1 | Clears the held peak |
| selWrite | input | 1 | Select write strobe |
| selKind | input | 2 | 0 held peak, 1 current max, 2 current min, 3 one link |
| selLink | input | 3 | Link number for kind 3 |
| rdDelay | output | 11 | Delay returned by the last completed select |
| rdLink | output | 3 | Link number returned by the last completed select |
| busy | output | 1 | High while a select is being served |

## Verification
The assertions take for granted that reset is applied before any strobe is trusted. They also assume that heldClr is the only thing that may lower the peak. The peak and ordering properties hold for any mix of updates and mask changes. The bench checks peak contents with a model that expects each new state to stay in place for a few cycles. For that reason, the random stimulus changes one thing at a time (one update, one mask value or one clear) and then lets three quiet cycles pass before it issues a select. It never overlaps a change with a read, except in the directed cases that deliberately test holding and restarting.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  typedef enum logic [1:0] {
    KIND_HELD = 2'd0,
    KIND_CMAX = 2'd1,
    KIND_CMIN = 2'd2,
    KIND_LINK = 2'd3
  } delay_kind_e;

  typedef struct packed {
    logic snapEn;
    logic loadEn;
  } ctrl_strb_t;
endpackage

// File: rtl/ldm_extreme.sv
module ldm_extreme #(
  parameter int NUM_LINKS = 8,
  parameter int DELAY_W   = 11,
  parameter int LINK_W    = 3,
  parameter bit FIND_MAX  = 1'b1
) (
  input  logic [NUM_LINKS*DELAY_W-1:0] delays,
  input  logic [NUM_LINKS-1:0]         mask,
  output logic [DELAY_W-1:0]           bestVal,
  output logic [LINK_W-1:0]            bestLink
);
  logic                found;
  logic [DELAY_W-1:0]  cand;
  logic                better;

  always_comb begin
    found    = 1'b0;
    bestVal  = '0;
    bestLink = '0;
    cand     = '0;
    better   = 1'b0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      cand = delays[i*DELAY_W +: DELAY_W];
      if (FIND_MAX) better = cand > bestVal;
      else          better = cand < bestVal;
      if (mask[i] && (!found || better)) begin
        bestVal  = cand;
        bestLink = LINK_W'(i);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ldm_ctrl.sv
module ldm_ctrl
  import ldm_pkg::*;
#(
  parameter int LINK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selWrite,
  input  logic [1:0]        selKind,
  input  logic [LINK_W-1:0] selLink,
  output ctrl_strb_t        strb,
  output delay_kind_e       kindQ,
  output logic [LINK_W-1:0] linkQ,
  output logic              busy
);
  logic [1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 2'd0;
      kindQ <= KIND_HELD;
      linkQ <= '0;
    end else if (selWrite) begin
      phase <= 2'd1;
      kindQ <= delay_kind_e'(selKind);
      linkQ <= selLink;
    end else if (phase == 2'd1) begin
      phase <= 2'd2;
    end else begin
      phase <= 2'd0;
    end
  end

  always_comb begin
    strb.snapEn = (phase == 2'd1);
    strb.loadEn = (phase == 2'd2);
    busy        = (phase != 2'd0);
  end

  // R8
  busy_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadEn && !selWrite) |=> !busy);
  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    selWrite |=> strb.snapEn);
endmodule

// File: rtl/ldm_datapath.sv
module ldm_datapath
  import ldm_pkg::*;
#(
  parameter int NUM_LINKS = 8,
  parameter int DELAY_W   = 11,
  parameter int LINK_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 updValid,
  input  logic [LINK_W-1:0]    updLink,
  input  logic [DELAY_W-1:0]   updDelay,
  input  logic [NUM_LINKS-1:0] groupMask,
  input  logic                 heldClr,
  input  ctrl_strb_t           strb,
  input  delay_kind_e          kindQ,
  input  logic [LINK_W-1:0]    linkQ,
  output logic [DELAY_W-1:0]   rdDelay,
  output logic [LINK_W-1:0]    rdLink
);
  logic [DELAY_W-1:0]           delayQ [NUM_LINKS];
  logic [NUM_LINKS*DELAY_W-1:0] delayFlat;
  logic [DELAY_W-1:0]           maxVal, minVal, curMaxQ, curMinQ, heldQ, snapVal, muxVal;
  logic [LINK_W-1:0]            maxLink, minLink, curMaxLinkQ, curMinLinkQ, heldLinkQ;
  logic [LINK_W-1:0]            snapLink, muxLink;

  generate
    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
      always_ff @(posedge clk) begin
        if (!rst_n)
          delayQ[g] <= '0;
        else if (updValid && (int'(updLink) == g))
          delayQ[g] <= updDelay;
      end
      assign delayFlat[g*DELAY_W +: DELAY_W] = delayQ[g];
    end
  endgenerate

  ldm_extreme #(.NUM_LINKS(NUM_LINKS), .DELAY_W(DELAY_W), .LINK_W(LINK_W), .FIND_MAX(1'b1))
    maxSearch_i (.delays(delayFlat), .mask(groupMask), .bestVal(maxVal), .bestLink(maxLink));
  ldm_extreme #(.NUM_LINKS(NUM_LINKS), .DELAY_W(DELAY_W), .LINK_W(LINK_W), .FIND_MAX(1'b0))
    minSearch_i (.delays(delayFlat), .mask(groupMask), .bestVal(minVal), .bestLink(minLink));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curMaxQ     <= '0;
      curMaxLinkQ <= '0;
      curMinQ     <= '0;
      curMinLinkQ <= '0;
    end else begin
      curMaxQ     <= maxVal;
      curMaxLinkQ <= maxLink;
      curMinQ     <= minVal;
      curMinLinkQ <= minLink;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || heldClr) begin
      heldQ     <= '0;
      heldLinkQ <= '0;
    end else if (curMaxQ > heldQ) begin
      heldQ     <= curMaxQ;
      heldLinkQ <= curMaxLinkQ;
    end
  end

  always_comb begin
    muxVal  = '0;
    muxLink = '0;
    unique case (kindQ)
      KIND_HELD: begin muxVal = heldQ;   muxLink = heldLinkQ;   end
      KIND_CMAX: begin muxVal = curMaxQ; muxLink = curMaxLinkQ; end
      KIND_CMIN: begin muxVal = curMinQ; muxLink = curMinLinkQ; end
      KIND_LINK: begin
        muxLink = linkQ;
        for (int i = 0; i < NUM_LINKS; i++)
          if (int'(linkQ) == i) muxVal = delayQ[i];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snapVal  <= '0;
      snapLink <= '0;
      rdDelay  <= '0;
      rdLink   <= '0;
    end else begin
      if (strb.snapEn) begin
        snapVal  <= muxVal;
        snapLink <= muxLink;
      end
      if (strb.loadEn) begin
        rdDelay <= snapVal;
        rdLink  <= snapLink;
      end
    end
  end

  // R6
  held_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !heldClr |=> heldQ >= $past(heldQ));
  // R6
  held_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !heldClr |=> heldQ >= $past(curMaxQ));
  // R3 R4
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    curMaxQ >= curMinQ);
  // R7
  held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    heldClr |=> (heldQ == '0) && (heldLinkQ == '0));
endmodule

// File: rtl/link_delay_monitor.sv
module link_delay_monitor
  import ldm_pkg::*;
#(
  parameter int NUM_LINKS = 8,
  parameter int DELAY_W   = 11,
  localparam int LINK_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 updValid,
  input  logic [LINK_W-1:0]    updLink,
  input  logic [DELAY_W-1:0]   updDelay,
  input  logic [NUM_LINKS-1:0] groupMask,
  input  logic                 heldClr,
  input  logic                 selWrite,
  input  logic [1:0]           selKind,
  input  logic [LINK_W-1:0]    selLink,
  output logic [DELAY_W-1:0]   rdDelay,
  output logic [LINK_W-1:0]    rdLink,
  output logic                 busy
);
  ctrl_strb_t        strb;
  delay_kind_e       kindQ;
  logic [LINK_W-1:0] linkQ;

  ldm_ctrl #(.LINK_W(LINK_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .selWrite(selWrite), .selKind(selKind),
    .selLink(selLink), .strb(strb), .kindQ(kindQ), .linkQ(linkQ), .busy(busy));

  ldm_datapath #(.NUM_LINKS(NUM_LINKS), .DELAY_W(DELAY_W), .LINK_W(LINK_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .updValid(updValid), .updLink(updLink),
    .updDelay(updDelay), .groupMask(groupMask), .heldClr(heldClr), .strb(strb),
    .kindQ(kindQ), .linkQ(linkQ), .rdDelay(rdDelay), .rdLink(rdLink));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !selWrite) |=> ($stable(rdDelay) && $stable(rdLink)));
endmodule

// File: tb/link_delay_monitor_tb.sv
module link_delay_monitor_tb_top;
  localparam int NL = 8;
  localparam int DW = 11;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic updValid = 1'b0;
  logic [LW-1:0] updLink = '0;
  logic [DW-1:0] updDelay = '0;
  logic [NL-1:0] groupMask = '0;
  logic heldClr = 1'b0;
  logic selWrite = 1'b0;
  logic [1:0] selKind = '0;
  logic [LW-1:0] selLink = '0;
  logic [DW-1:0] rdDelay;
  logic [LW-1:0] rdLink;
  logic busy;

  int checks = 0;
  int fails  = 0;
  int mDelay [NL];
  int mHeld = 0, mHeldLink = 0;

  always #4 clk = ~clk;

  link_delay_monitor dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mExt(input bit isMax, output int lnk);
    int best = 0;
    bit found = 0;
    lnk = 0;
    for (int i = 0; i < NL; i++)
      if (groupMask[i] && (!found || (isMax ? mDelay[i] > best : mDelay[i] < best))) begin
        best = mDelay[i]; lnk = i; found = 1;
      end
    return best;
  endfunction

  task automatic settle();
    int l, v;
    v = mExt(1'b1, l);
    if (v > mHeld) begin mHeld = v; mHeldLink = l; end
    repeat (3) @(negedge clk);
  endtask

  task automatic update(input int lnk, input int val);
    updValid = 1; updLink = LW'(lnk); updDelay = DW'(val);
    @(negedge clk);
    updValid = 0;
    mDelay[lnk] = val;
    settle();
  endtask

  task automatic read(input int kind, input int lnk, input string req);
    int expV, expL;
    case (kind)
      0: begin expV = mHeld; expL = mHeldLink; end
      1: expV = mExt(1'b1, expL);
      2: expV = mExt(1'b0, expL);
      default: begin expV = mDelay[lnk]; expL = lnk; end
    endcase
    selWrite = 1; selKind = 2'(kind); selLink = LW'(lnk);
    @(negedge clk);
    selWrite = 0;
    check("R8 busy 1st", busy, 1);
    @(negedge clk);
    check("R8 busy 2nd", busy, 1);
    @(negedge clk);
    check("R8 busy low", busy, 0);
    check({req, " delay"}, rdDelay, expV);
    check({req, " link"}, rdLink, expL);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed = 1234;
    int r, prevD, prevL;
    void'($urandom(seed));
    for (int i = 0; i < NL; i++) mDelay[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdDelay", rdDelay, 0);
    check("R1 rdLink", rdLink, 0);
    check("R1 busy", busy, 0);
    read(0, 0, "R1 held");
    read(3, 5, "R1 link5");

    // R2 per-link writes
    groupMask = 8'hFF;
    update(2, 300);
    update(5, 12);
    read(3, 2, "R2 link2");
    read(3, 5, "R2 link5");
    // R3 / R4 with ties: links 1 and 6 share the max
    update(1, 900);
    update(6, 900);
    read(1, 0, "R3 max tie");
    read(2, 0, "R4 min");
    // R5 masked link with huge delay ignored
    update(7, 2000);
    groupMask = 8'h7F; settle();
    read(1, 0, "R5 max masked");
    groupMask = 8'h7E; settle();
    read(2, 0, "R5 min masked");
    // R6 held peak kept link 7 from before masking
    read(0, 0, "R6 held");
    // R4 empty mask
    groupMask = 8'h00; settle();
    read(1, 0, "R4 empty max");
    read(2, 0, "R4 empty min");
    // R7 clear with empty mask
    heldClr = 1; @(negedge clk); heldClr = 0;
    mHeld = 0; mHeldLink = 0; settle();
    read(0, 0, "R7 held cleared");
    groupMask = 8'hFF; settle();
    read(0, 0, "R6 held reload");

    // R9 outputs hold while idle
    read(3, 2, "R9 setup");
    prevD = rdDelay; prevL = rdLink;
    update(2, 77);
    heldClr = 1; @(negedge clk); heldClr = 0;
    mHeld = 0; mHeldLink = 0; settle();
    check("R9 hold delay", rdDelay, prevD);
    check("R9 hold link", rdLink, prevL);

    // R10 restart: second select one cycle later wins
    selWrite = 1; selKind = 2'd3; selLink = 3'd5;
    @(negedge clk);
    selKind = 2'd3; selLink = 3'd2;
    @(negedge clk);
    selWrite = 0;
    check("R10 busy", busy, 1);
    check("R10 old not loaded", rdDelay, prevD);
    @(negedge clk);
    check("R10 busy 2nd", busy, 1);
    @(negedge clk);
    check("R10 busy low", busy, 0);
    check("R10 delay", rdDelay, mDelay[2]);
    check("R10 link", rdLink, 2);

    // random phase
    for (int it = 0; it < 60; it++) begin
      r = $urandom_range(0, 9);
      if (r < 6) update($urandom_range(0, NL-1), $urandom_range(0, 2047));
      else if (r < 9) begin groupMask = NL'($urandom_range(0, 255)); settle(); end
      else begin
        heldClr = 1; @(negedge clk); heldClr = 0;
        mHeld = 0; mHeldLink = 0; settle();
      end
      r = $urandom_range(0, 3);
      case (r)
        0: read(0, 0, "R6 rand held");
        1: read(1, 0, "R3 rand max");
        2: read(2, 0, "R4 rand min");
        default: read(3, $urandom_range(0, NL-1), "R2 rand link");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule